// File: doc/BRIEF.md
# Bus Interface Reset Quiesce Controller

This block sits between a bus interface unit and the central reset unit. When the reset unit raises a level warning that an internal reset is coming, the controller puts the bus interface into a quiet state. On the outbound side it stops the bus request: a request that is raised but has not started is pulled back, and no new request is let through. A transaction that is already running is left to finish. On the inbound side it stops claiming new transactions, so initiators get a master abort. Requests on the internal side pass through unchanged during the drain.

Once both sides are quiet, the block raises a ready-for-reset handshake. It holds that handshake until the reset unit applies its reset pulse. A mode strap picks the behaviour. In endpoint mode (strap 0) the block drains first, and the reset clears only queues and state machines. In central-resource mode (strap 1) it reports ready at once, and the reset also clears the configuration registers.

Top module: `busq_reset_ctrl`

## Requirements
- R1: From the cycle after `rst_warn` is sampled high in the idle state, `bus_req_out` is low whatever `req_pending` does. It stays low until the controller is back in idle, one cycle after `bus_reset` is sampled low. Outside that window `bus_req_out` equals `req_pending`.
- R2: In endpoint mode the controller stays draining, with `ready_for_reset` low, in every cycle where `xfer_active` is high and `xfer_done` is low. A cycle with `xfer_active` low, or with `xfer_done` high, counts as the transaction having ended.
- R3: `claim_inhibit` is high from the cycle after the warning is sampled until the controller returns to idle.
- R4: `ib_req_out` always equals `ib_req_in`, in every state.
- R5: In endpoint mode `ready_for_reset` rises one cycle after the first clock edge at which the outbound side has ended and no bit of `inbound_busy` is set.
- R6: In central-resource mode (`mode_strap` = 1), `ready_for_reset` is high in the cycle right after the warning is sampled, whatever the bus activity.
- R7: While the reset is applied, that is from the cycle after `bus_reset` is sampled high until the return to idle, `queue_clr` is high. `cfg_reset_en` is high in that window only when `mode_strap` is 1.
- R8: Once high, `ready_for_reset` stays high until `bus_reset` is sampled high.
- R9: After draining has begun, dropping `rst_warn` has no effect. The controller stays inhibited and still goes on to ready.
- R10: `bus_reset` sampled high in any state, including idle with no warning, moves the controller into the reset state on the next cycle.
- R11: An active-low `rst_n` sets the controller to idle at once, with `bus_req_out` following `req_pending` and every other control output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_warn | input | 1 | Level warning that an internal reset is coming |
| mode_strap | input | 1 | 0 = endpoint (drain, keep config), 1 = central resource |
| bus_reset | input | 1 | Reset pulse from the central reset unit, active high |
| req_pending | input | 1 | Bus master logic wants the external bus |
| xfer_active | input | 1 | An outbound transaction is in progress |
| xfer_done | input | 1 | The running transaction ends in this cycle |
| inbound_busy | input | IB_SRC | Inbound activity flags, one per source |
| ib_req_in | input | 1 | Internal-side request from the interface |
| bus_req_out | output | 1 | Gated external bus request |
| req_inhibit | output | 1 | New outbound requests are suppressed |
| claim_inhibit | output | 1 | New inbound transactions are not claimed |
| ready_for_reset | output | 1 | Sideband handshake to the reset unit |
| queue_clr | output | 1 | Clear queues and state machines |
| cfg_reset_en | output | 1 | Clear configuration registers as well |
| ib_req_out | output | 1 | Internal-side request, passed through |

## Verification
The bench targets a request that is pending when the warning arrives. A design that let that request through would start a bus transaction the reset is about to cut off. It holds a transaction active across a dropped warning and then ends it with a done pulse while inbound is still busy. A design that trusted the warning level, or looked only at the outbound side, would raise ready too early. It runs the central-resource strap with heavy activity, where a design that drained anyway would stall the reset unit. It checks that configuration clearing follows the strap, since getting this wrong would wipe endpoint settings. It also applies a reset pulse with no warning, and a power-on reset in the middle of a drain.

// File: rtl/busq_pkg.sv
package busq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_READY = 2'd2,
        ST_RESET = 2'd3
    } busq_state_e;

    typedef struct packed {
        busq_state_e st;
    } busq_ctl_t;
endpackage

// File: rtl/busq_drain_mon.sv
module busq_drain_mon #(
    parameter int IB_SRC = 2
) (
    input  logic              xfer_active,
    input  logic              xfer_done,
    input  logic [IB_SRC-1:0] inbound_busy,
    output logic              all_quiet
);
    logic ob_quiet;
    logic ib_quiet;

    always_comb begin
        ob_quiet  = !xfer_active || xfer_done;
        ib_quiet  = ~|inbound_busy;
        all_quiet = ob_quiet && ib_quiet;
    end
endmodule

// File: rtl/busq_fsm.sv
module busq_fsm
    import busq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rst_warn,
    input  logic        mode_strap,
    input  logic        bus_reset,
    input  logic        all_quiet,
    output busq_state_e state_q
);
    busq_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (bus_reset) begin
            ctl_d.st = ST_RESET;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE:  if (rst_warn) ctl_d.st = mode_strap ? ST_READY : ST_DRAIN;
                ST_DRAIN: if (all_quiet) ctl_d.st = ST_READY;
                ST_READY: ctl_d.st = ST_READY;
                ST_RESET: ctl_d.st = ST_IDLE;
                default:  ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE};
        else        ctl_q <= ctl_d;
    end

    assign state_q = ctl_q.st;

    // R10
    bus_reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> state_q == ST_RESET);

    // R9
    drain_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !bus_reset && !all_quiet) |=> state_q == ST_DRAIN);
endmodule

// File: rtl/busq_reset_ctrl.sv
module busq_reset_ctrl
    import busq_pkg::*;
#(
    parameter int IB_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_warn,
    input  logic              mode_strap,
    input  logic              bus_reset,
    input  logic              req_pending,
    input  logic              xfer_active,
    input  logic              xfer_done,
    input  logic [IB_SRC-1:0] inbound_busy,
    input  logic              ib_req_in,
    output logic              bus_req_out,
    output logic              req_inhibit,
    output logic              claim_inhibit,
    output logic              ready_for_reset,
    output logic              queue_clr,
    output logic              cfg_reset_en,
    output logic              ib_req_out
);
    logic        all_quiet;
    busq_state_e state_q;

    busq_drain_mon #(.IB_SRC(IB_SRC)) u_mon (
        .xfer_active (xfer_active),
        .xfer_done   (xfer_done),
        .inbound_busy(inbound_busy),
        .all_quiet   (all_quiet)
    );

    busq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_warn  (rst_warn),
        .mode_strap(mode_strap),
        .bus_reset (bus_reset),
        .all_quiet (all_quiet),
        .state_q   (state_q)
    );

    always_comb begin
        req_inhibit     = (state_q != ST_IDLE);
        claim_inhibit   = (state_q != ST_IDLE);
        bus_req_out     = req_pending && !req_inhibit;
        ready_for_reset = (state_q == ST_READY);
        queue_clr       = (state_q == ST_RESET);
        cfg_reset_en    = (state_q == ST_RESET) && mode_strap;
        ib_req_out      = ib_req_in;
    end

    // R1
    warn_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_warn && !bus_reset) |=> !bus_req_out);

    // R6
    central_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_inhibit && rst_warn && mode_strap && !bus_reset) |=> ready_for_reset);

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_for_reset && !bus_reset) |=> ready_for_reset);

    // R5
    no_early_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_inhibit && !ready_for_reset && !all_quiet && !bus_reset) |=> !ready_for_reset);

    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_clr && !bus_reset) |=> !claim_inhibit);
endmodule

// File: tb/busq_reset_ctrl_test.sv
module busq_reset_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_warn = 1'b0, mode_strap = 1'b0, bus_reset = 1'b0;
    logic req_pending = 1'b0, xfer_active = 1'b0, xfer_done = 1'b0, ib_req_in = 1'b0;
    logic [1:0] inbound_busy = 2'b00;
    logic bus_req_out, req_inhibit, claim_inhibit, ready_for_reset;
    logic queue_clr, cfg_reset_en, ib_req_out;
    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    busq_reset_ctrl #(.IB_SRC(2)) uut (
        .clk(clk), .rst_n(rst_n), .rst_warn(rst_warn), .mode_strap(mode_strap),
        .bus_reset(bus_reset), .req_pending(req_pending), .xfer_active(xfer_active),
        .xfer_done(xfer_done), .inbound_busy(inbound_busy), .ib_req_in(ib_req_in),
        .bus_req_out(bus_req_out), .req_inhibit(req_inhibit),
        .claim_inhibit(claim_inhibit), .ready_for_reset(ready_for_reset),
        .queue_clr(queue_clr), .cfg_reset_en(cfg_reset_en), .ib_req_out(ib_req_out)
    );

    // stim: [7]warn [6]strap [5]req [4]active [3]done [2]inbound busy [1]bus_reset [0]ib_req
    // exp : [6]bus_req [5]req_inh [4]claim_inh [3]ready [2]queue_clr [1]cfg_clr [0]ib_req_out
    localparam int NV = 19;
    localparam logic [7:0] STIM [NV] = '{
        8'b0010_0001, 8'b1010_0000, 8'b1010_0000, 8'b0000_0000, 8'b0000_0010,
        8'b0000_0010, 8'b0000_0001, 8'b1001_0100, 8'b0001_0100, 8'b0001_1100,
        8'b0010_0100, 8'b0000_0000, 8'b0000_0010, 8'b0000_0000, 8'b1101_0100,
        8'b0100_0010, 8'b0110_0000, 8'b0000_0010, 8'b0000_0000 };
    localparam logic [6:0] EXPV [NV] = '{
        7'b1000001, 7'b0110000, 7'b0111000, 7'b0111000, 7'b0110100,
        7'b0110100, 7'b0000001, 7'b0110000, 7'b0110000, 7'b0110000,
        7'b0110000, 7'b0111000, 7'b0110100, 7'b0000000, 7'b0111000,
        7'b0110110, 7'b1000000, 7'b0110100, 7'b0000000 };
    localparam string TAG [NV] = '{
        "R4 idle passthrough", "R1 R3 pending request withdrawn", "R5 quiet drain to ready",
        "R8 R9 ready held after warn drop", "R7 endpoint reset keeps config", "R7 reset held",
        "R8 R1 back to idle", "R2 mid transaction drain", "R9 warn drop ignored",
        "R2 done pulse but inbound busy", "R1 R5 request blocked while inbound busy",
        "R5 both quiet ready", "R7 reset", "R8 idle again", "R6 central ready at once",
        "R7 central reset clears config", "R1 central back to idle", "R10 reset without warning",
        "R10 idle after reset"
    };

    function automatic logic [6:0] outs();
        return {bus_req_out, req_inhibit, claim_inhibit, ready_for_reset,
                queue_clr, cfg_reset_en, ib_req_out};
    endfunction

    task automatic apply(input logic [7:0] s);
        {rst_warn, mode_strap, req_pending, xfer_active, xfer_done} = s[7:3];
        inbound_busy = {1'b0, s[2]};
        bus_reset = s[1];
        ib_req_in = s[0];
    endtask

    task automatic check(input logic [6:0] exp, input string what);
        n_vec++;
        if (outs() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", what, outs(), exp);
        end
    endtask

    initial begin
        // R11 reset state, with request passing through
        req_pending = 1'b1;
        #15;
        check(7'b1000000, "R11 power-on reset state");
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); apply(STIM[i]);
            @(posedge clk); #2;
            check(EXPV[i], TAG[i]);
        end
        // R11 asynchronous reset during a drain
        @(negedge clk); apply(8'b1001_0000);
        @(posedge clk); #2;
        check(7'b0110000, "R11 drain entered");
        #3 rst_n = 1'b0; #1;
        check(7'b0000000, "R11 async reset mid drain");
        @(negedge clk); apply(8'b0000_0000); rst_n = 1'b1;
        // R2 upper inbound source alone keeps drain going
        @(negedge clk); rst_warn = 1'b1; inbound_busy = 2'b10;
        @(posedge clk); #2; check(7'b0110000, "R2 drain with upper inbound busy");
        @(posedge clk); #2; check(7'b0110000, "R5 no ready while inbound busy");
        @(negedge clk); inbound_busy = 2'b00; rst_warn = 1'b0;
        @(posedge clk); #2; check(7'b0111000, "R5 ready after inbound idle");
        // R10 reset pulse straight from ready
        @(negedge clk); bus_reset = 1'b1;
        @(posedge clk); #2; check(7'b0110100, "R10 reset from ready");
        @(negedge clk); bus_reset = 1'b0;
        @(posedge clk); #2; check(7'b0000000, "R8 idle after reset");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule